// File: doc/BRIEF.md
# Audio Output Sample Formatter

This block sits between a memory reader and a serial audio transmitter. It takes 32-bit words as they were fetched from memory, splits them into samples and puts out one left/right pair each time the transmitter asks for one. A two-bit mode picks both the sample width (16 or 32 bits) and the channel count (mono or stereo). In mono modes the single sample goes to both channels.

An endianness setting tells the block how bytes were laid out in memory. A sign-conversion setting flips the top bit of every output sample, which turns two's-complement data into offset-binary or the reverse. Each output channel is a 32-bit field. A 16-bit sample sits in its upper half with the lower half zero. The settings take effect only while the block holds no part of a word, so a change in the middle of a word leaves the samples already fetched unchanged.

Top module: `aof_fmt`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_left and out_right are 0, and the active settings are mode 00, big-endian, no sign conversion.
- R2: In mode 00 (mono, 32-bit) each accepted word yields one pair, with out_left equal to out_right.
- R3: In mode 01 (stereo, 32-bit) two consecutive accepted words yield one pair. The first word is the left channel and the second is the right.
- R4: In mode 10 (mono, 16-bit) each accepted word yields two pairs. The lower-address sample comes first, and each sample is copied to both channels.
- R5: In mode 11 (stereo, 16-bit) each accepted word yields one pair, with the lower-address half on the left and the higher-address half on the right.
- R6: Memory byte k (address offset k) arrives on in_word[8k+7:8k]. With cfg_le = 0 (big-endian) a 32-bit sample is {byte0,byte1,byte2,byte3} and 16-bit sample i is {byte(2i),byte(2i+1)}. With cfg_le = 1 (little-endian) the byte order within each sample is reversed.
- R7: A 16-bit sample is placed in bits 31:16 of its output channel, and bits 15:0 are 0.
- R8: With cfg_sign_inv = 1, bit 31 of both output channels is inverted. With cfg_sign_inv = 0, the samples pass through unchanged.
- R9: in_ready is 0 while any pair from the last accepted word has not yet been delivered, so a new word is taken only after the previous one is fully used.
- R10: The mode, endianness and sign settings are latched only while no word or half pair is held. A change made between the two words of a 32-bit stereo pair has no effect on that pair.
- R11: A one-cycle pulse on smp_req yields exactly one out_valid pulse, two cycles later if a pair is ready. If no pair is ready, the request is held until data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mode: 00 mono/32, 01 stereo/32, 10 mono/16, 11 stereo/16 |
| cfg_le | input | 1 | 0 big-endian memory, 1 little-endian |
| cfg_sign_inv | input | 1 | 1 inverts the MSB of each output sample |
| in_word | input | 32 | Memory word, byte k on bits 8k+7:8k |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| smp_req | input | 1 | Request for one output pair |
| out_left | output | 32 | Left channel sample |
| out_right | output | 32 | Right channel sample |
| out_valid | output | 1 | One-cycle pulse when a new pair is on the outputs |

## Verification
The hardest state to reach is the gap inside a 32-bit stereo pair. One word is held and the second has not arrived, so the block is neither empty nor able to serve a pair. The bench feeds the first word, changes every setting, and only then supplies the second word and a request. It checks that the pair still follows the settings that applied to its first word. A request made while the block holds nothing is also tested. The bench watches out_valid stay low for several cycles and then expects the pair once a word arrives.

// File: rtl/aof_pkg.sv
package aof_pkg;

    typedef enum logic [1:0] {
        MODE_MONO32 = 2'b00,
        MODE_ST32   = 2'b01,
        MODE_MONO16 = 2'b10,
        MODE_ST16   = 2'b11
    } aof_mode_e;

    typedef struct packed {
        aof_mode_e mode;
        logic      le;
        logic      sinv;
    } aof_cfg_t;

    localparam aof_cfg_t CFG_RESET = '{mode: MODE_MONO32, le: 1'b0, sinv: 1'b0};

endpackage

// File: rtl/aof_lane_pick.sv
module aof_lane_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   word_i,
    input  logic                le_i,
    output logic [DATA_W-1:0]   full_o,
    output logic [DATA_W/2-1:0] first_o,
    output logic [DATA_W/2-1:0] second_o
);
    localparam int NBYTES = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] rev_w;

    // full byte reversal of the bus word
    for (genvar k = 0; k < NBYTES; k++) begin : g_rev
        assign rev_w[8*k +: 8] = word_i[8*(NBYTES-1-k) +: 8];
    end

    always_comb begin
        full_o = le_i ? word_i : rev_w;
        // lower address half comes first in either byte order
        if (le_i) begin
            first_o  = full_o[HALF_W-1:0];
            second_o = full_o[DATA_W-1:HALF_W];
        end else begin
            first_o  = full_o[DATA_W-1:HALF_W];
            second_o = full_o[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/aof_sign_fix.sv
module aof_sign_fix #(
    parameter int DATA_W = 32,
    parameter int NCH    = 2
) (
    input  logic [NCH-1:0][DATA_W-1:0] smp_i,
    input  logic                       inv_i,
    output logic [NCH-1:0][DATA_W-1:0] smp_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign smp_o[c] = {smp_i[c][DATA_W-1] ^ inv_i, smp_i[c][DATA_W-2:0]};
    end
endmodule

// File: rtl/aof_fmt.sv
module aof_fmt
    import aof_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_le,
    input  logic              cfg_sign_inv,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              smp_req,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              out_valid
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] hold_a;
        logic [DATA_W-1:0] hold_b;
        logic [1:0]        avail;
        logic              half;
        logic              pend;
        aof_cfg_t          cfg;
        logic [DATA_W-1:0] out_l;
        logic [DATA_W-1:0] out_r;
        logic              out_v;
    } aof_state_t;

    aof_state_t st_d, st_q;

    logic                     idle_w;
    aof_cfg_t                 cfg_eff;
    logic                     accept;
    logic                     serve;
    logic [DATA_W-1:0]        full_w;
    logic [HALF_W-1:0]        first_w, second_w;
    logic [1:0][DATA_W-1:0]   raw_pair, fixed_pair;
    logic [1:0]               act_mode;

    assign idle_w   = (st_q.avail == 2'd0) && !st_q.half;
    assign cfg_eff  = idle_w ? aof_cfg_t'{mode: aof_mode_e'(cfg_mode), le: cfg_le, sinv: cfg_sign_inv}
                             : st_q.cfg;
    assign in_ready = (st_q.avail == 2'd0);
    assign accept   = in_valid && in_ready;
    assign serve    = st_q.pend && (st_q.avail != 2'd0);
    assign act_mode = st_q.cfg.mode;

    aof_lane_pick #(.DATA_W(DATA_W)) u_pick (
        .word_i   (in_word),
        .le_i     (cfg_eff.le),
        .full_o   (full_w),
        .first_o  (first_w),
        .second_o (second_w)
    );

    // pair selection from the hold registers
    always_comb begin
        raw_pair = '0;
        unique case (st_q.cfg.mode)
            MODE_MONO32: begin
                raw_pair[0] = st_q.hold_a;
                raw_pair[1] = st_q.hold_a;
            end
            MODE_MONO16: begin
                raw_pair[0] = (st_q.avail == 2'd2) ? st_q.hold_a : st_q.hold_b;
                raw_pair[1] = raw_pair[0];
            end
            default: begin
                raw_pair[0] = st_q.hold_a;
                raw_pair[1] = st_q.hold_b;
            end
        endcase
    end

    aof_sign_fix #(.DATA_W(DATA_W), .NCH(2)) u_sign (
        .smp_i (raw_pair),
        .inv_i (st_q.cfg.sinv),
        .smp_o (fixed_pair)
    );

    always_comb begin
        st_d       = st_q;
        st_d.out_v = 1'b0;
        st_d.cfg   = cfg_eff;
        st_d.pend  = (st_q.pend && !serve) || smp_req;

        if (serve) begin
            st_d.out_l = fixed_pair[0];
            st_d.out_r = fixed_pair[1];
            st_d.out_v = 1'b1;
            st_d.avail = st_q.avail - 2'd1;
        end

        if (accept) begin
            unique case (cfg_eff.mode)
                MODE_MONO32: begin
                    st_d.hold_a = full_w;
                    st_d.avail  = 2'd1;
                end
                MODE_ST32: begin
                    if (!st_q.half) begin
                        st_d.hold_a = full_w;
                        st_d.half   = 1'b1;
                    end else begin
                        st_d.hold_b = full_w;
                        st_d.half   = 1'b0;
                        st_d.avail  = 2'd1;
                    end
                end
                MODE_MONO16: begin
                    st_d.hold_a = {first_w, {HALF_W{1'b0}}};
                    st_d.hold_b = {second_w, {HALF_W{1'b0}}};
                    st_d.avail  = 2'd2;
                end
                default: begin
                    st_d.hold_a = {first_w, {HALF_W{1'b0}}};
                    st_d.hold_b = {second_w, {HALF_W{1'b0}}};
                    st_d.avail  = 2'd1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hold_a: '0, hold_b: '0, avail: 2'd0, half: 1'b0, pend: 1'b0,
                      cfg: CFG_RESET, out_l: '0, out_r: '0, out_v: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_left  = st_q.out_l;
    assign out_right = st_q.out_r;
    assign out_valid = st_q.out_v;

endmodule

// File: rtl/aof_chk.sv
module aof_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic [1:0]        act_mode,
    input logic              idle_w
);
    localparam int HALF_W = DATA_W / 2;

    // R2 R4
    mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !act_mode[0]) |-> (out_left == out_right));

    // R7
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_mode[1]) |-> (out_left[HALF_W-1:0] == '0 && out_right[HALF_W-1:0] == '0));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_w |=> $stable(act_mode));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !idle_w);
endmodule

bind aof_fmt aof_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .act_mode  (act_mode),
    .idle_w    (idle_w)
);

// File: tb/tb_aof_fmt.sv
module tb_aof_fmt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_le = 1'b0;
    logic        cfg_sign_inv = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        smp_req = 1'b0;
    logic [31:0] out_left, out_right;
    logic        out_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] got_l, got_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    aof_fmt dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_le(cfg_le),
        .cfg_sign_inv(cfg_sign_inv), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .smp_req(smp_req), .out_left(out_left),
        .out_right(out_right), .out_valid(out_valid)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            finish_run();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(logic [31:0] w, int k);
        return w[8*k +: 8];
    endfunction

    function automatic logic [31:0] exp32(logic [31:0] w, logic le);
        if (le) return {byte_at(w,3), byte_at(w,2), byte_at(w,1), byte_at(w,0)};
        return {byte_at(w,0), byte_at(w,1), byte_at(w,2), byte_at(w,3)};
    endfunction

    function automatic logic [31:0] exp16(logic [31:0] w, logic le, int i);
        if (le) return {byte_at(w,2*i+1), byte_at(w,2*i), 16'h0000};
        return {byte_at(w,2*i), byte_at(w,2*i+1), 16'h0000};
    endfunction

    task automatic send_word(logic [31:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_word = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out(string req);
        int t = 0;
        while (!out_valid && t < 20) begin @(negedge clk); t++; end
        n_chk++;
        if (!out_valid) begin
            n_fail++;
            $display("FAIL %s: actual out_valid 0 expected 1", req);
        end
        got_l = out_left; got_r = out_right;
    endtask

    task automatic get_pair(string req);
        @(negedge clk);
        smp_req = 1'b1;
        @(negedge clk);
        smp_req = 1'b0;
        wait_out(req);
    endtask

    task automatic set_cfg(logic [1:0] m, logic le, logic si);
        @(negedge clk);
        cfg_mode = m; cfg_le = le; cfg_sign_inv = si;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 out_left", out_left, 32'd0);
        check("R1 out_right", out_right, 32'd0);
    endtask

    task automatic t_mono32();
        set_cfg(2'b00, 1'b0, 1'b0);
        send_word(32'h44332211);
        get_pair("R2");
        check("R2 R6 left be", got_l, exp32(32'h44332211, 1'b0));
        check("R2 right", got_r, got_l);
        set_cfg(2'b00, 1'b1, 1'b0);
        send_word(32'hA1B2C3D4);
        get_pair("R2");
        check("R6 left le", got_l, exp32(32'hA1B2C3D4, 1'b1));
        check("R2 right le", got_r, exp32(32'hA1B2C3D4, 1'b1));
    endtask

    task automatic t_st32();
        set_cfg(2'b01, 1'b1, 1'b0);
        send_word(32'h01020304);
        send_word(32'h0A0B0C0D);
        get_pair("R3");
        check("R3 left", got_l, 32'h01020304);
        check("R3 right", got_r, 32'h0A0B0C0D);
    endtask

    task automatic t_mono16(logic le);
        set_cfg(2'b10, le, 1'b0);
        send_word(32'hDDCCBBAA);
        @(negedge clk);
        check("R9 busy after accept", {31'd0, in_ready}, 32'd0);
        get_pair("R4");
        check("R4 R6 first", got_l, exp16(32'hDDCCBBAA, le, 0));
        check("R4 dup first", got_r, exp16(32'hDDCCBBAA, le, 0));
        @(negedge clk);
        check("R9 busy one left", {31'd0, in_ready}, 32'd0);
        get_pair("R4");
        check("R4 R7 second", got_l, exp16(32'hDDCCBBAA, le, 1));
        check("R4 dup second", got_r, exp16(32'hDDCCBBAA, le, 1));
        @(negedge clk);
        check("R9 ready when drained", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_st16();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_word(32'h12345678);
        get_pair("R5");
        check("R5 left", got_l, 32'h56780000);
        check("R5 right", got_r, 32'h12340000);
        set_cfg(2'b11, 1'b0, 1'b0);
        send_word(32'h12345678);
        get_pair("R5");
        check("R5 R6 left be", got_l, exp16(32'h12345678, 1'b0, 0));
        check("R5 R6 right be", got_r, exp16(32'h12345678, 1'b0, 1));
    endtask

    task automatic t_sign();
        set_cfg(2'b00, 1'b1, 1'b1);
        send_word(32'h00000001);
        get_pair("R8");
        check("R8 mono32 inv", got_l, 32'h80000001);
        set_cfg(2'b11, 1'b1, 1'b1);
        send_word(32'h80007FFF);
        get_pair("R8");
        check("R8 left inv", got_l, 32'hFFFF0000);
        check("R8 right inv", got_r, 32'h00000000);
    endtask

    task automatic t_cfg_idle();
        set_cfg(2'b01, 1'b1, 1'b0);
        send_word(32'hCAFE0001);
        set_cfg(2'b10, 1'b0, 1'b1);
        send_word(32'hBEEF0002);
        get_pair("R10");
        check("R10 left held cfg", got_l, 32'hCAFE0001);
        check("R10 right held cfg", got_r, 32'hBEEF0002);
        set_cfg(2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_pending();
        set_cfg(2'b00, 1'b1, 1'b0);
        @(negedge clk);
        smp_req = 1'b1;
        @(negedge clk);
        smp_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R11 no pair without data", {31'd0, out_valid}, 32'd0);
        end
        send_word(32'h5A5A1234);
        wait_out("R11");
        check("R11 pending served", got_l, 32'h5A5A1234);
        @(negedge clk);
        check("R11 single pulse", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mono32();
        t_st32();
        t_mono16(1'b0);
        t_mono16(1'b1);
        t_st16();
        t_sign();
        t_cfg_idle();
        t_pending();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule